// File: doc/BRIEF.md
# SMBus Indexed Block Register Target

This block is a bus target for a two-wire SMBus/I2C-style link. It gives a host access to a small array of byte registers. The host uses indexed block transfers only. The block samples the clock and data lines on a fast system clock. It recognises start, repeated start and stop conditions, and it answers to one fixed 7-bit device address. It pulls the shared data line low to acknowledge a byte and to send read data.

In a write, the host sends the device address with the direction bit clear. It then sends a starting index, a byte count, and that many data bytes. The data bytes fill consecutive registers, and the index wraps at the end of the array. In a read, the host sends the address and the index, then a repeated start and the address with the direction bit set. The target first returns the contents of a designated count register. It then streams registers from the index onward for as long as the host acknowledges.

Top module: `smbt_target`

## Requirements
- R1: After reset the data-line pull-down `sda_oe` is released (0), and it stays released while no transaction is in progress.
- R2: An address byte of 0xD4 (write) or 0xD5 (read), that is device address 0x6A in bits 7:1 with the direction in bit 0, is acknowledged. Any other address byte is not acknowledged, and every later byte up to the next start is neither acknowledged nor stored.
- R3: In a write, the index byte, the count byte and each data byte up to the count are acknowledged. Data byte k is stored in register index+k.
- R4: Register indexes wrap modulo 16. The low 4 bits of the index byte select the first register, and the index after register 15 is register 0, on both writes and reads.
- R5: A write with count 0 is acknowledged through the count byte and changes no register.
- R6: A data byte beyond the announced count is not acknowledged and is not stored.
- R7: After a repeated start and 0xD5, the first byte sent is the value of register 8. Registers from the index onward follow, most significant bit first.
- R8: When the host does not acknowledge a read byte, the target releases the data line and drives nothing until the next start or stop.
- R9: The target changes `sda_oe` only while SCL is low. A stop returns it to idle with the data line released.
- R10: The index set by the last index byte persists after a stop. A read that opens directly with 0xD5 continues from it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8 times the bus bit rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | When 1, the pad pulls the data line low |

## Verification
A wrong bit counter or a wrong frame state shows at the ports within one byte frame. An acknowledge appears or goes missing at the ninth clock, or read data lands shifted by one bit in the next byte sent. A wrong register pointer stays hidden until the next read. That read then returns data from the wrong register, or the wrong count byte, right after the read address. For this reason every write in the sweep is followed by a full read-back of the array. An error in skip-until-start handling shows as a pull-down during clocks that should have been left alone, or as a register changed by bytes that should have been ignored.

// File: rtl/smbt_pkg.sv
package smbt_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_INDEX,
      ST_COUNT,
      ST_WDATA,
      ST_TXCNT,
      ST_TXDATA,
      ST_SKIP
   } smbt_state_e;
endpackage

// File: rtl/smbt_sync.sv
module smbt_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_raw,
   input  logic sda_raw,
   output logic scl,
   output logic sda,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   logic [STAGES-1:0] scl_pipe, sda_pipe;
   logic              scl_q, sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_pipe <= '1;
         sda_pipe <= '1;
         scl_q    <= 1'b1;
         sda_q    <= 1'b1;
      end else begin
         scl_pipe <= {scl_pipe[STAGES-2:0], scl_raw};
         sda_pipe <= {sda_pipe[STAGES-2:0], sda_raw};
         scl_q    <= scl;
         sda_q    <= sda;
      end
   end

   assign scl       = scl_pipe[STAGES-1];
   assign sda       = sda_pipe[STAGES-1];
   assign scl_rise  = scl & ~scl_q;
   assign scl_fall  = ~scl & scl_q;
   assign start_det = scl & scl_q & sda_q & ~sda;
   assign stop_det  = scl & scl_q & ~sda_q & sda;
endmodule

// File: rtl/smbt_regfile.sv
module smbt_regfile #(
   parameter int DEPTH = 16,
   parameter int AW    = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [7:0]    wdata,
   input  logic [AW-1:0] raddr_a,
   output logic [7:0]    rdata_a,
   input  logic [AW-1:0] raddr_b,
   output logic [7:0]    rdata_b
);
   logic [7:0] mem [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (we) begin
         mem[waddr] <= wdata;
      end
   end

   assign rdata_a = mem[raddr_a];
   assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/smbt_target.sv
module smbt_target #(
   parameter logic [6:0] DEV_ADDR    = 7'h6A,
   parameter int         NUM_REGS    = 16,
   parameter int         CNT_REG     = 8,
   parameter int         SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic sda_oe
);
   import smbt_pkg::*;

   localparam int IDX_W = $clog2(NUM_REGS);

   if (NUM_REGS < 2 || (1 << IDX_W) != NUM_REGS)
      $error("NUM_REGS must be a power of two of at least 2");
   if (CNT_REG < 0 || CNT_REG >= NUM_REGS)
      $error("CNT_REG must index the register array");
   if (SYNC_STAGES < 2)
      $error("SYNC_STAGES must be at least 2");

   logic scl, sda, scl_rise, scl_fall, start_det, stop_det;

   smbt_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .scl_raw(scl_i), .sda_raw(sda_i),
      .scl(scl), .sda(sda), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_det(start_det), .stop_det(stop_det)
   );

   smbt_state_e      st, nxt_st;
   logic [3:0]       bit_cnt;
   logic [7:0]       rx_sh, tx_sh, remain;
   logic [IDX_W-1:0] ptr;
   logic             ack_pend, sda_oe_q;
   logic [7:0]       rx_byte, rdata_ptr, rdata_cnt;
   logic             we, is_rx, is_tx;

   assign rx_byte = {rx_sh[6:0], sda};
   assign is_rx   = (st == ST_ADDR) || (st == ST_INDEX) || (st == ST_COUNT) || (st == ST_WDATA);
   assign is_tx   = (st == ST_TXCNT) || (st == ST_TXDATA);
   assign we      = scl_rise && (bit_cnt == 4'd7) && (st == ST_WDATA) && (remain != 8'd0)
                    && !start_det && !stop_det;

   smbt_regfile #(.DEPTH(NUM_REGS), .AW(IDX_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .we(we), .waddr(ptr), .wdata(rx_byte),
      .raddr_a(ptr), .rdata_a(rdata_ptr),
      .raddr_b(IDX_W'(CNT_REG)), .rdata_b(rdata_cnt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         nxt_st   <= ST_IDLE;
         bit_cnt  <= '0;
         rx_sh    <= '0;
         tx_sh    <= '0;
         remain   <= '0;
         ptr      <= '0;
         ack_pend <= 1'b0;
         sda_oe_q <= 1'b0;
      end else if (start_det) begin
         st       <= ST_ADDR;
         bit_cnt  <= '0;
         ack_pend <= 1'b0;
         sda_oe_q <= 1'b0;
      end else if (stop_det) begin
         st       <= ST_IDLE;
         bit_cnt  <= '0;
         sda_oe_q <= 1'b0;
      end else if (st != ST_IDLE && st != ST_SKIP) begin
         if (scl_rise) begin
            if (bit_cnt != 4'd9) bit_cnt <= bit_cnt + 4'd1;
            if (is_rx && bit_cnt < 4'd8) rx_sh <= rx_byte;
            if (is_rx && bit_cnt == 4'd7) begin
               unique case (st)
                  ST_ADDR: begin
                     ack_pend <= (rx_byte[7:1] == DEV_ADDR);
                     if (rx_byte[7:1] != DEV_ADDR) nxt_st <= ST_SKIP;
                     else nxt_st <= rx_byte[0] ? ST_TXCNT : ST_INDEX;
                  end
                  ST_INDEX: begin
                     ptr      <= rx_byte[IDX_W-1:0];
                     ack_pend <= 1'b1;
                     nxt_st   <= ST_COUNT;
                  end
                  ST_COUNT: begin
                     remain   <= rx_byte;
                     ack_pend <= 1'b1;
                     nxt_st   <= ST_WDATA;
                  end
                  default: begin
                     if (remain != 8'd0) begin
                        ptr      <= ptr + 1'b1;
                        remain   <= remain - 8'd1;
                        ack_pend <= 1'b1;
                        nxt_st   <= ST_WDATA;
                     end else begin
                        ack_pend <= 1'b0;
                        nxt_st   <= ST_SKIP;
                     end
                  end
               endcase
            end
            if (is_tx && bit_cnt == 4'd8) nxt_st <= sda ? ST_SKIP : ST_TXDATA;
         end else if (scl_fall) begin
            if (bit_cnt == 4'd8) begin
               sda_oe_q <= is_rx & ack_pend;
            end else if (bit_cnt == 4'd9) begin
               bit_cnt <= '0;
               st      <= nxt_st;
               if (nxt_st == ST_TXCNT) begin
                  tx_sh    <= rdata_cnt;
                  sda_oe_q <= ~rdata_cnt[7];
               end else if (nxt_st == ST_TXDATA) begin
                  tx_sh    <= rdata_ptr;
                  sda_oe_q <= ~rdata_ptr[7];
                  ptr      <= ptr + 1'b1;
               end else begin
                  sda_oe_q <= 1'b0;
               end
            end else if (is_tx && bit_cnt != 4'd0) begin
               tx_sh    <= {tx_sh[6:0], 1'b0};
               sda_oe_q <= ~tx_sh[6];
            end
         end
      end
   end

   assign sda_oe = sda_oe_q;
endmodule

// File: rtl/smbt_target_chk.sv
module smbt_target_chk #(
   parameter int IDX_W = 4
) (
   input logic                clk,
   input logic                rst_n,
   input logic                scl_i,
   input logic                sda_oe,
   input smbt_pkg::smbt_state_e st,
   input logic [3:0]          bit_cnt,
   input logic                we,
   input logic [IDX_W-1:0]    ptr,
   input logic                start_det,
   input logic                stop_det
);
   import smbt_pkg::*;

   // R9
   sda_change_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_oe) |-> !scl_i);

   // R9
   stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> (!sda_oe && st == ST_IDLE));

   // R1
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE) |-> !sda_oe);

   // R8
   skip_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_SKIP) |-> !sda_oe);

   // R2
   start_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_det |=> (st == ST_ADDR && bit_cnt == 4'd0));

   // R4
   ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> ((ptr - $past(ptr)) == IDX_W'(1)));

   // R3
   bit_cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bit_cnt <= 4'd9);
endmodule

bind smbt_target smbt_target_chk #(.IDX_W(IDX_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe), .st(st),
   .bit_cnt(bit_cnt), .we(we), .ptr(ptr), .start_det(start_det), .stop_det(stop_det)
);

// File: tb/smbt_target_bench.sv
module smbt_target_bench;
   localparam int CLK_PERIOD = 10;
   localparam int Q          = 6;

   logic clk = 1'b0, rst_n = 1'b0, scl_m = 1'b1, sda_m = 1'b1;
   logic sda_oe, sda_line;
   int   n_chk = 0, n_bad = 0;
   bit   done = 1'b0;
   logic [7:0] model [16];
   logic [7:0] wbuf  [16];

   assign sda_line = sda_m & ~sda_oe;
   always #(CLK_PERIOD/2) clk = ~clk;

   smbt_target u_smbt_target (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_start;
      sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
      sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
   endtask

   task automatic bus_stop;
      sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q);
      sda_m = 1'b1; tick(Q);
   endtask

   task automatic wbyte(input logic [7:0] b, output bit ack);
      for (int i = 7; i >= 0; i--) begin
         sda_m = b[i]; tick(Q); scl_m = 1'b1; tick(Q); scl_m = 1'b0; tick(Q);
      end
      sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
      ack = !sda_line;
      scl_m = 1'b0; tick(Q);
   endtask

   task automatic rbyte(output logic [7:0] b, input bit ack);
      sda_m = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         tick(Q); scl_m = 1'b1; tick(Q); b[i] = sda_line; scl_m = 1'b0;
      end
      tick(Q); sda_m = !ack; tick(Q); scl_m = 1'b1; tick(Q); scl_m = 1'b0; tick(Q);
      sda_m = 1'b1;
   endtask

   task automatic do_write(input int idx, input int cnt);
      bit a;
      bus_start;
      wbyte(8'hD4, a);          chk(a, "R2 write address ack", a, 1);
      wbyte(8'(idx), a);        chk(a, "R3 index ack", a, 1);
      wbyte(8'(cnt), a);        chk(a, "R3/R5 count ack", a, 1);
      for (int i = 0; i < cnt; i++) begin
         wbyte(wbuf[i], a);     chk(a, "R3 data ack", a, 1);
         model[(idx + i) % 16] = wbuf[i];
      end
      bus_stop;
   endtask

   task automatic do_read(input int idx, input int len, input string req);
      bit a;
      logic [7:0] b;
      bus_start;
      wbyte(8'hD4, a);          chk(a, "R2 address ack", a, 1);
      wbyte(8'(idx), a);        chk(a, "R7 index ack", a, 1);
      sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
      wbyte(8'hD5, a);          chk(a, "R2 read address ack", a, 1);
      rbyte(b, len > 0);        chk(b == model[8], "R7 count byte", b, model[8]);
      for (int i = 0; i < len; i++) begin
         rbyte(b, i < len - 1);
         chk(b == model[(idx + i) % 16], req, b, model[(idx + i) % 16]);
      end
      bus_stop;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog expired");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      bit a;
      logic [7:0] b;
      for (int i = 0; i < 16; i++) model[i] = 8'h00;
      tick(4);
      chk(sda_oe == 1'b0, "R1 reset release", sda_oe, 0);
      rst_n = 1'b1;
      tick(4);
      chk(sda_oe == 1'b0, "R1 idle release", sda_oe, 0);

      // R3 / R4: three-byte writes at every start index, wrapping at the top
      for (int n = 0; n < 16; n++) begin
         for (int i = 0; i < 3; i++) wbuf[i] = 8'((n * 29 + i * 7 + 8'h3C) & 8'hFF);
         do_write(n, 3);
      end
      wbuf[0] = 8'd16;
      do_write(8, 1);
      do_read(0, 16, "R3 full readback");
      do_read(13, 5, "R4 wrapped read");

      // R5: zero count leaves registers untouched
      do_write(2, 0);
      do_read(2, 1, "R5 zero count no update");

      // R6: byte past the count is refused
      bus_start;
      wbyte(8'hD4, a); wbyte(8'h04, a); wbyte(8'h01, a);
      wbyte(8'hA7, a); chk(a, "R6 in-count ack", a, 1); model[4] = 8'hA7;
      wbyte(8'h5B, a); chk(!a, "R6 excess nack", a, 0);
      bus_stop;
      do_read(4, 2, "R6 excess not stored");

      // R2: near-miss and foreign addresses are ignored until the next start
      bus_start;
      wbyte(8'hD6, a); chk(!a, "R2 wrong address nack", a, 0);
      wbyte(8'h03, a); chk(!a, "R2 ignored index", a, 0);
      wbyte(8'h01, a); chk(!a, "R2 ignored count", a, 0);
      wbyte(8'hEE, a); chk(!a, "R2 ignored data", a, 0);
      bus_stop;
      bus_start;
      wbyte(8'hA0, a); chk(!a, "R2 foreign address nack", a, 0);
      bus_stop;
      do_read(3, 1, "R2 ignored bytes not stored");

      // R8: host NACKs the count byte; target stays off the line
      bus_start;
      wbyte(8'hD4, a); wbyte(8'h00, a);
      sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
      wbyte(8'hD5, a);
      rbyte(b, 1'b0); chk(b == model[8], "R8 count before nack", b, model[8]);
      for (int i = 0; i < 9; i++) begin
         tick(Q); scl_m = 1'b1; tick(Q);
         chk(sda_line == 1'b1, "R8 released after nack", sda_line, 1);
         scl_m = 1'b0;
      end
      tick(Q);
      bus_stop;
      tick(2);
      chk(sda_oe == 1'b0, "R9 released after stop", sda_oe, 0);

      // R10: index survives a stop; read opens directly with 0xD5
      bus_start;
      wbyte(8'hD4, a); wbyte(8'h0B, a); chk(a, "R10 index ack", a, 1);
      bus_stop;
      bus_start;
      wbyte(8'hD5, a); chk(a, "R10 direct read ack", a, 1);
      rbyte(b, 1'b1); chk(b == model[8], "R10 count byte", b, model[8]);
      rbyte(b, 1'b0); chk(b == model[11], "R10 continues at index", b, model[11]);
      bus_stop;

      // R4: index byte with high bits set uses its low nibble
      wbuf[0] = 8'h99;
      bus_start;
      wbyte(8'hD4, a); wbyte(8'hF1, a); wbyte(8'h01, a); wbyte(wbuf[0], a);
      bus_stop;
      model[1] = 8'h99;
      do_read(0, 3, "R4 low nibble index");

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule